// File: doc/BRIEF.md
# Parallel CRC Generator and Checker

This block computes a cyclic redundancy remainder over a framed message stream and accepts several message bits on every clock. The generator polynomial, the remainder width and the number of data bits per word are parameters. The serial polynomial divider is unrolled so that one clock advances the remainder by a whole data word. The hardware is the same as a chain of single-bit shift-and-conditional-XOR steps, and the chain collapses into one layer of XOR logic.

A frame opens with a start pulse that clears the remainder to zero. Each word strobed as valid then advances the remainder, oldest bit first. On the transmit side the remainder is read after the last message word and appended to the message. On the receive side the same datapath takes the message and the appended remainder. When the frame-end pulse arrives, a flag reports whether the final remainder is zero, which means the codeword is intact.

Top module: `crc_par_engine`

## Requirements
- R1: While reset is asserted and after it is released, `crc_o` is zero and `chk_ok_o` is 0 until the first frame activity.
- R2: A cycle with `sof_i` high and `valid_i` low leaves `crc_o` equal to zero in the following cycle.
- R3: A cycle with both `valid_i` and `sof_i` low leaves `crc_o` unchanged in the following cycle, whatever `data_i` and `eof_i` carry.
- R4: One cycle after each valid word, `crc_o` equals (M(x)·x^n) mod G(x). M is every bit accepted since the last start, n is `CRC_W`, and G has a leading term x^n plus the low coefficients in `POLY`. With the default x^8+x^2+x+1 (`POLY` = 0x07), the nine bytes 0x31 to 0x39 give 0xF4.
- R5: The bits of a word are consumed most significant first: bit `DATA_W-1` is the oldest. With the default parameters, a lone word 0x01 gives 0x07 and a lone word 0x80 gives 0x89.
- R6: When `sof_i` and `valid_i` are high together, the word is divided starting from a zero remainder. Everything before it is discarded.
- R7: In the cycle after `eof_i` is high, `chk_ok_o` is 1 exactly when `crc_o` is zero. `crc_o` there includes the word of the end cycle if that word was valid.
- R8: `chk_ok_o` changes only after an end cycle or a start cycle. A start cycle without an end clears it to 0.
- R9: A message followed by its own remainder word, ended with `eof_i`, raises `chk_ok_o`. The same frame with a single flipped message bit does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Frame start: clears the remainder before this cycle's word |
| valid_i | input | 1 | `data_i` carries a message word this cycle |
| data_i | input | DATA_W | Message word, most significant bit first |
| eof_i | input | 1 | Frame end: samples the zero test of the updated remainder |
| crc_o | output | CRC_W | Current remainder |
| chk_ok_o | output | 1 | Last ended frame left a zero remainder |

## Verification
The bound checker watches the framing rules on every cycle:
- idle cycles hold the remainder;
- a bare start clears it;
- the flag moves only on start or end cycles, and after an end it agrees with the zero test of the remainder;
- a zero word applied to a zero remainder keeps it zero.

The arithmetic itself cannot be checked by a property. Correct division, bit order, the start-with-word case and good or bad codewords only show through the bench's scenarios. There, a long-division model over the bit queue is compared with the outputs every clock, and fixed known values are checked as well.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;
   // upper bound kept modest so unrolled chains stay small
   localparam int unsigned CRC_MAX_W  = 64;
   localparam int unsigned DATA_MAX_W = 128;

   // the constant coefficient of a usable generator must be set
   function automatic bit poly_has_unit(input logic [CRC_MAX_W-1:0] p);
      return p[0];
   endfunction
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
   parameter int unsigned    CRC_W = 8,
   parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
   input  logic [CRC_W-1:0] rem_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] rem_o
);
   logic fb;

   // divide by G: the bit leaving the top meets the incoming message bit
   assign fb    = rem_i[CRC_W-1] ^ bit_i;
   assign rem_o = {rem_i[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/crc_word_next.sv
module crc_word_next #(
   parameter int unsigned    CRC_W  = 8,
   parameter int unsigned    DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY   = 8'h07
) (
   input  logic [CRC_W-1:0]  rem_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  rem_o
);
   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = rem_i;

   // unrolled divider: stage k has absorbed the k oldest bits (MSB first)
   for (genvar k = 0; k < DATA_W; k++) begin : g_step
      crc_bit_step #(
         .CRC_W (CRC_W),
         .POLY  (POLY)
      ) u_step (
         .rem_i (stage[k]),
         .bit_i (data_i[DATA_W-1-k]),
         .rem_o (stage[k+1])
      );
   end

   assign rem_o = stage[DATA_W];
endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine #(
   parameter int unsigned    CRC_W  = 8,
   parameter int unsigned    DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY   = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              eof_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              chk_ok_o
);
   import crc_par_pkg::*;

   localparam logic [CRC_MAX_W-1:0] POLY_EXT = CRC_MAX_W'(POLY);

   // elaboration-time parameter checks
   if (CRC_W < 2 || CRC_W > CRC_MAX_W) begin : g_bad_crc_w
      $error("crc_par_engine: CRC_W out of range");
   end
   if (DATA_W < 1 || DATA_W > DATA_MAX_W) begin : g_bad_data_w
      $error("crc_par_engine: DATA_W out of range");
   end
   if (!poly_has_unit(POLY_EXT)) begin : g_bad_poly
      $error("crc_par_engine: POLY needs its constant term");
   end

   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] rem_base;
   logic [CRC_W-1:0] rem_word;
   logic [CRC_W-1:0] rem_d;
   logic             ok_q;

   // a start discards history before this cycle's word is applied
   assign rem_base = sof_i ? '0 : rem_q;

   crc_word_next #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY)
   ) u_next (
      .rem_i  (rem_base),
      .data_i (data_i),
      .rem_o  (rem_word)
   );

   assign rem_d = valid_i ? rem_word : rem_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else begin
         rem_q <= rem_d;
      end
   end

   // frame-end verdict; an end in the same cycle as a start takes precedence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q <= 1'b0;
      end else if (eof_i) begin
         ok_q <= (rem_d == '0);
      end else if (sof_i) begin
         ok_q <= 1'b0;
      end
   end

   assign crc_o    = rem_q;
   assign chk_ok_o = ok_q;
endmodule

// File: rtl/crc_par_engine_chk.sv
module crc_par_engine_chk #(
   parameter int unsigned CRC_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sof_i,
   input logic              valid_i,
   input logic [DATA_W-1:0] data_i,
   input logic              eof_i,
   input logic [CRC_W-1:0]  crc_o,
   input logic              chk_ok_o
);
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !sof_i) |=> $stable(crc_o)); // R3

   AST_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !valid_i) |=> (crc_o == '0)); // R2

   AST_ZERO_WORD_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !sof_i && crc_o == '0 && data_i == '0) |=> (crc_o == '0)); // R4

   AST_EOF_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      eof_i |=> (chk_ok_o == (crc_o == '0))); // R7

   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!eof_i && !sof_i) |=> $stable(chk_ok_o)); // R8

   AST_SOF_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !eof_i) |=> !chk_ok_o); // R8
endmodule

bind crc_par_engine crc_par_engine_chk #(
   .CRC_W  (CRC_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sof_i    (sof_i),
   .valid_i  (valid_i),
   .data_i   (data_i),
   .eof_i    (eof_i),
   .crc_o    (crc_o),
   .chk_ok_o (chk_ok_o)
);

// File: tb/test_crc_par_engine.sv
module test_crc_par_engine;
   localparam int unsigned      CW    = 8;
   localparam int unsigned      DW    = 8;
   localparam logic [CW-1:0]    GPOLY = 8'h07;
   localparam time              CLK_P = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof = 1'b0;
   logic          valid = 1'b0;
   logic [DW-1:0] data = '0;
   logic          eof = 1'b0;
   logic [CW-1:0] crc;
   logic          ok;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   bit            msg_q[$];
   logic [CW-1:0] exp_rem = '0;
   logic          exp_ok = 1'b0;

   crc_par_engine #(
      .CRC_W  (CW),
      .DATA_W (DW),
      .POLY   (GPOLY)
   ) i_crc_par_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof_i    (sof),
      .valid_i  (valid),
      .data_i   (data),
      .eof_i    (eof),
      .crc_o    (crc),
      .chk_ok_o (ok)
   );

   always #(CLK_P/2) clk = ~clk;

   // long division of the message (times x^n) by G over a bit list
   function automatic logic [CW-1:0] ref_div(input bit m[$]);
      bit               w[$];
      bit               g[CW+1];
      logic [CW-1:0]    r;
      w = m;
      for (int z = 0; z < CW; z++) w.push_back(1'b0);
      g[0] = 1'b1;
      for (int k = 1; k <= CW; k++) g[k] = GPOLY[CW-k];
      for (int i = 0; i + CW < w.size(); i++) begin
         if (w[i]) begin
            for (int k = 0; k <= CW; k++) w[i+k] = w[i+k] ^ g[k];
         end
      end
      for (int j = 0; j < CW; j++) r[CW-1-j] = w[w.size()-CW+j];
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge: drive, advance the model, compare one cycle later
   task automatic step(input logic s, input logic v, input logic [DW-1:0] d,
                       input logic e, input string tag);
      sof = s; valid = v; data = d; eof = e;
      if (s) msg_q.delete();
      if (v) for (int b = DW-1; b >= 0; b--) msg_q.push_back(d[b]);
      exp_rem = ref_div(msg_q);
      if (e) exp_ok = (exp_rem == '0);
      else if (s) exp_ok = 1'b0;
      @(negedge clk);
      check({tag, " crc"}, 64'(crc), 64'(exp_rem));
      check({tag, " flag"}, 64'(ok), 64'(exp_ok));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [CW-1:0] held;
      logic [CW-1:0] rcrc;
      logic [DW-1:0] frm[6];

      repeat (3) @(negedge clk);
      check("R1 reset crc", 64'(crc), 64'h0);
      check("R1 reset flag", 64'(ok), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release crc", 64'(crc), 64'h0);
      check("R1 after release flag", 64'(ok), 64'h0);

      // R5: bit ordering with lone words
      step(1, 1, 8'h01, 0, "R5 lone 01");
      check("R5 0x01 value", 64'(crc), 64'h07);
      step(1, 1, 8'h80, 0, "R5 lone 80");
      check("R5 0x80 value", 64'(crc), 64'h89);

      // R4: known nine-byte vector
      for (int c = 0; c < 9; c++) step(c == 0, 1, 8'(8'h31 + c), 0, "R4 vector");
      check("R4 known value", 64'(crc), 64'hF4);

      // R3: idle cycles with noise on data and eof-free
      held = crc;
      step(0, 0, 8'hA5, 0, "R3 idle");
      step(0, 0, 8'h5A, 0, "R3 idle");
      check("R3 held", 64'(crc), 64'(held));

      // R9: append remainder and end frame
      step(0, 1, 8'hF4, 1, "R9 codeword");
      check("R9 good flag", 64'(ok), 64'h1);
      check("R7 zero remainder", 64'(crc), 64'h0);

      // R8: flag holds over idle and data cycles
      step(0, 0, 8'h00, 0, "R8 hold");
      step(0, 1, 8'h3C, 0, "R8 hold data");
      check("R8 flag kept", 64'(ok), 64'h1);

      // R2: bare start clears remainder and flag
      step(1, 0, 8'hFF, 0, "R2 bare start");
      check("R2 cleared", 64'(crc), 64'h0);
      check("R8 start clears flag", 64'(ok), 64'h0);

      // R6: start together with a word restarts from zero
      step(0, 1, 8'h77, 0, "R6 history");
      step(1, 1, 8'h01, 0, "R6 start+word");
      check("R6 restart value", 64'(crc), 64'h07);

      // R7: end with nonzero remainder and no word
      step(0, 0, 8'h00, 1, "R7 end nonzero");
      check("R7 bad flag", 64'(ok), 64'h0);

      // R9: corrupted codeword
      for (int c = 0; c < 9; c++)
         step(c == 0, 1, (c == 4) ? 8'h34 ^ 8'h10 : 8'(8'h31 + c), 0, "R9 corrupt");
      step(0, 1, 8'hF4, 1, "R9 corrupt end");
      check("R9 corrupt flag", 64'(ok), 64'h0);

      // R4 R7 R9: random frames with gaps, own remainder appended
      for (int f = 0; f < 40; f++) begin
         for (int i = 0; i < 6; i++) frm[i] = 8'($urandom);
         for (int i = 0; i < 6; i++) begin
            step(i == 0, 1, frm[i], 0, "R4 random");
            if ($urandom_range(0, 2) == 0) step(0, 0, 8'($urandom), 0, "R3 random gap");
         end
         rcrc = crc;
         step(0, 1, rcrc, 1, "R9 random codeword");
         check("R9 random flag", 64'(ok), 64'h1);
      end

      finish_run();
   end
endmodule